// File: doc/BRIEF.md
# Byte-Lane Bus Cycle Sequencer

The sequencer sits between a CPU-side load/store port and a 16-bit little-endian processor bus that has a 24-bit byte address space. Each request gives a byte address, a size of one, two or four bytes, a direction and up to 32 bits of write data. The block turns the request into the fewest bus cycles that respect the two byte lanes. It drives the word address, the active-low lane enables and the steered write data for each cycle. For a read, it collects each returned byte into a right-justified result.

Unaligned two- and four-byte transfers are legal and never fault. An odd start address puts its first byte on the high lane on its own. The low-lane and high-lane enables therefore describe address bit 0 of the bytes on the bus, not which half of the value those bytes came from. The bus side ends each cycle with an acknowledge, and the cycle holds until that acknowledge arrives. The requester sees a busy flag while a transfer runs and a one-cycle done pulse when it ends.

Top module: `bus_lane_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, no bus cycle is active, both lane enables are high (inactive), done is low and busy is low.
- R2: A request is taken in a cycle where req_valid is high and busy is low. Busy is high from the next cycle until the cycle of the done pulse, when it drops. A request presented while busy is high is ignored and starts no bus cycle.
- R3: bus_waddr is bits 23..1 of the byte address of the first byte in the current cycle. The bytes of a split transfer go out in increasing address order.
- R4: The low lane (bits 7..0) is enabled by bus_ble_n = 0 and carries the byte whose address has bit 0 = 0. The high lane (bits 15..8) is enabled by bus_bhe_n = 0 and carries the byte whose address has bit 0 = 1. A lane is enabled only when it carries a byte of the transfer, every active cycle enables at least one lane, and both enables are 1 when no cycle is active.
- R5: req_size encodes the byte count: 00 is 1 byte, 01 is 2 bytes, 10 and 11 are 4 bytes. The number of bus cycles is 1 for a byte, 1 for an even 2-byte access, 2 for an odd 2-byte access, 2 for an even 4-byte access and 3 for an odd 4-byte access.
- R6: In a write cycle, byte k of req_wdata (bits 8k+7..8k, least significant byte first) goes to the lane that matches the address bit 0 of address+k. A lane that is not enabled carries zero. In read cycles bus_wdata is zero.
- R7: A read result puts the byte from address+k into rdata bits 8k+7..8k. Bytes past the requested size are zero, and data on lanes that are not enabled is ignored.
- R8: done is a single-cycle pulse in the cycle after the acknowledge of the last bus cycle, and rdata holds the result in that cycle.
- R9: Address steps wrap modulo 2^24, so a transfer that starts at 0xFFFFFF continues at 0x000000.
- R10: While bus_cyc is high and bus_ack is low, the address, enables, direction and write data hold steady into the next cycle.
- R11: bus_we equals the direction of the request (1 = write) in every cycle of the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 24 | Byte address of the least significant byte |
| req_size | input | 2 | Byte count code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write value, right-justified |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished (one-cycle pulse) |
| rdata | output | 32 | Read result, right-justified |
| bus_cyc | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle direction |
| bus_waddr | output | 23 | Word address, byte address bits 23..1 |
| bus_ble_n | output | 1 | Low-lane enable, active low |
| bus_bhe_n | output | 1 | High-lane enable, active low |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data from the bus |
| bus_ack | input | 1 | Ends the current bus cycle |

## Verification
The bench targets odd starts of two- and four-byte transfers. A design that split them wrongly would emit the wrong number of cycles, or put the first byte on the low lane of the wrong word. It writes at 0xFFFFFF, where a carry into bit 24 or an unwrapped address would send the tail bytes to a bad word. It also drives junk on lanes that are not enabled, which a design that captures whole words would pull into rdata. Acknowledges arrive after varying delays, and requests are poked while the block is busy, so a design that advanced without an acknowledge or accepted a second request would produce extra or misaddressed cycles.

// File: rtl/bls_pkg.sv
package bls_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } size_e;

    // One bus cycle: which lanes are enabled and how many bytes it moves
    typedef struct packed {
        logic [LANES-1:0] en;
        logic [1:0]       nbytes;
    } lane_plan_t;

    function automatic int unsigned size_to_bytes(input logic [1:0] code);
        case (size_e'(code))
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return 4;
        endcase
    endfunction

    // An odd address always takes the high lane alone; an even address
    // takes both lanes when at least two bytes remain.
    function automatic lane_plan_t plan_cycle(input logic odd, input int unsigned remaining);
        lane_plan_t p;
        p = '0;
        if (odd) begin
            p.en     = 2'b10;
            p.nbytes = 2'd1;
        end else if (remaining >= 2) begin
            p.en     = 2'b11;
            p.nbytes = 2'd2;
        end else begin
            p.en     = 2'b01;
            p.nbytes = 2'd1;
        end
        return p;
    endfunction

endpackage

// File: rtl/bls_ctrl.sv
module bls_ctrl
    import bls_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int MAX_BYTES = 4,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              bus_ack,
    output logic              active,
    output logic              done,
    output logic              start,
    output logic              capture,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  idx,
    output lane_plan_t        plan
);

    logic [CNT_W-1:0] remaining;
    logic [CNT_W-1:0] req_bytes;
    logic [CNT_W-1:0] step;

    always_comb begin
        int unsigned b;
        b = size_to_bytes(req_size);
        if (b > MAX_BYTES) b = MAX_BYTES;
        req_bytes = CNT_W'(b);
    end

    always_comb begin
        plan = plan_cycle(cur_addr[0], 32'(remaining));
        step = CNT_W'(plan.nbytes);
    end

    assign start   = req_valid && !active;
    assign capture = active && bus_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            done      <= 1'b0;
            cur_addr  <= '0;
            remaining <= '0;
            idx       <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active    <= 1'b1;
                cur_addr  <= req_addr;
                remaining <= req_bytes;
                idx       <= '0;
            end else if (capture) begin
                cur_addr  <= cur_addr + ADDR_W'(plan.nbytes);
                remaining <= remaining - step;
                idx       <= idx + step;
                if (remaining == step) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bls_wr_steer.sv
module bls_wr_steer
    import bls_pkg::*;
#(
    parameter int MAX_BYTES = 4,
    parameter int PW        = 4,
    localparam int DATA_W   = 8 * MAX_BYTES,
    localparam int BUS_W    = LANES * LANE_W
) (
    input  logic [DATA_W-1:0]         wdata,
    input  logic [LANES-1:0][PW-1:0]  lane_pos,
    input  logic [LANES-1:0]          lane_hit,
    output logic [BUS_W-1:0]          lane_data
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] sel;
        always_comb begin
            sel = '0;
            for (int b = 0; b < MAX_BYTES; b++) begin
                if (lane_hit[l] && lane_pos[l] == PW'(b))
                    sel = wdata[8*b +: 8];
            end
        end
        assign lane_data[LANE_W*l +: LANE_W] = sel;
    end

endmodule

// File: rtl/bls_rd_gather.sv
module bls_rd_gather
    import bls_pkg::*;
#(
    parameter int MAX_BYTES = 4,
    parameter int PW        = 4,
    localparam int DATA_W   = 8 * MAX_BYTES,
    localparam int BUS_W    = LANES * LANE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  logic                      capture,
    input  logic [LANES-1:0][PW-1:0]  lane_pos,
    input  logic [LANES-1:0]          lane_hit,
    input  logic [BUS_W-1:0]          lane_in,
    output logic [DATA_W-1:0]         result
);

    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                byte_q <= '0;
            end else if (capture) begin
                for (int l = 0; l < LANES; l++) begin
                    if (lane_hit[l] && lane_pos[l] == PW'(b))
                        byte_q <= lane_in[LANE_W*l +: LANE_W];
                end
            end
        end
        assign result[8*b +: 8] = byte_q;
    end

endmodule

// File: rtl/bus_lane_seq.sv
module bus_lane_seq
    import bls_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int MAX_BYTES = 4,
    localparam int DATA_W   = 8 * MAX_BYTES,
    localparam int BUS_W    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_cyc,
    output logic              bus_we,
    output logic [ADDR_W-2:0] bus_waddr,
    output logic              bus_ble_n,
    output logic              bus_bhe_n,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic              bus_ack
);

    localparam int CNT_W = $clog2(MAX_BYTES + 1);
    localparam int PW    = CNT_W + 1;

    logic              active;
    logic              start;
    logic              capture;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  idx;
    lane_plan_t        plan;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0][PW-1:0] lane_pos;
    logic [LANES-1:0]  lane_hit;
    logic [BUS_W-1:0]  steer_data;

    bls_ctrl #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_size (req_size),
        .bus_ack  (bus_ack),
        .active   (active),
        .done     (done),
        .start    (start),
        .capture  (capture),
        .cur_addr (cur_addr),
        .idx      (idx),
        .plan     (plan)
    );

    // Value byte index carried by each lane in the current cycle
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_pos[l] = PW'(idx) + PW'(l) - PW'(cur_addr[0]);
            lane_hit[l] = active && plan.en[l] && (lane_pos[l] < PW'(MAX_BYTES));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (start) begin
            we_q    <= req_write;
            wdata_q <= req_wdata;
        end
    end

    bls_wr_steer #(.MAX_BYTES(MAX_BYTES), .PW(PW)) u_steer (
        .wdata    (wdata_q),
        .lane_pos (lane_pos),
        .lane_hit (lane_hit),
        .lane_data(steer_data)
    );

    bls_rd_gather #(.MAX_BYTES(MAX_BYTES), .PW(PW)) u_gather (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .capture (capture && !we_q),
        .lane_pos(lane_pos),
        .lane_hit(lane_hit),
        .lane_in (bus_rdata),
        .result  (rdata)
    );

    assign busy      = active;
    assign bus_cyc   = active;
    assign bus_we    = we_q;
    assign bus_waddr = cur_addr[ADDR_W-1:1];
    assign bus_ble_n = !(active && plan.en[0]);
    assign bus_bhe_n = !(active && plan.en[1]);
    assign bus_wdata = (active && we_q) ? steer_data : '0;

endmodule

// File: rtl/bls_chk.sv
module bls_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              bus_cyc,
    input logic              bus_we,
    input logic [ADDR_W-2:0] bus_waddr,
    input logic              bus_ble_n,
    input logic              bus_bhe_n,
    input logic [15:0]       bus_wdata,
    input logic              bus_ack
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!bus_cyc && bus_ble_n && bus_bhe_n && !done && !busy));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    // R4
    live_lane_chk: assert property (@(posedge clk) disable iff (rst)
        bus_cyc |-> !(bus_ble_n && bus_bhe_n));

    // R4
    idle_lane_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_cyc |-> (bus_ble_n && bus_bhe_n));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && !bus_ack) |=> (bus_cyc && $stable(bus_waddr) && $stable(bus_ble_n)
                                   && $stable(bus_bhe_n) && $stable(bus_wdata) && $stable(bus_we)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_cyc && bus_ack));

endmodule

bind bus_lane_seq bls_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .busy     (busy),
    .done     (done),
    .bus_cyc  (bus_cyc),
    .bus_we   (bus_we),
    .bus_waddr(bus_waddr),
    .bus_ble_n(bus_ble_n),
    .bus_bhe_n(bus_bhe_n),
    .bus_wdata(bus_wdata),
    .bus_ack  (bus_ack)
);

// File: tb/bus_lane_seq_test.sv
module bus_lane_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        busy, done;
    logic [31:0] rdata;
    logic        bus_cyc, bus_we, bus_ble_n, bus_bhe_n;
    logic [22:0] bus_waddr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_lane_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .bus_cyc(bus_cyc),
        .bus_we(bus_we), .bus_waddr(bus_waddr), .bus_ble_n(bus_ble_n),
        .bus_bhe_n(bus_bhe_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack)
    );

    int checks = 0;
    int errors = 0;
    int cycle_no = 0;
    int cyc_seen = 0;
    int wait_left = 0;
    int stall_pat = 0;
    bit done_due = 0;

    typedef struct {
        logic [22:0] wa;
        logic        ble_n;
        logic        bhe_n;
        logic        we;
        logic [15:0] wd;
    } exp_t;

    exp_t expq[$];
    logic [7:0] mem [int unsigned];

    function automatic logic [7:0] mem_rd(input logic [23:0] a);
        if (mem.exists(32'(a))) return mem[32'(a)];
        return a[7:0] ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Bus responder and per-clock reference comparison
    always @(negedge clk) begin
        if (rst) begin
            bus_ack = 1'b0;
        end else begin
            if (done_due) begin
                check(done == 1'b1, "R8", "done after last ack", 32'(done), 32'd1);
                done_due = 0;
            end else begin
                check(done == 1'b0, "R8", "done outside end", 32'(done), 32'd0);
            end
            bus_ack = 1'b0;
            if (bus_cyc) begin
                check(expq.size() != 0, "R2", "unexpected bus cycle", 32'(bus_waddr), 32'd0);
                if (wait_left > 0) begin
                    wait_left--;
                end else if (expq.size() != 0) begin
                    exp_t e;
                    e = expq.pop_front();
                    check(bus_waddr == e.wa, "R3", "word address", 32'(bus_waddr), 32'(e.wa));
                    check(bus_ble_n == e.ble_n && bus_bhe_n == e.bhe_n, "R4", "lane enables",
                          {30'd0, bus_bhe_n, bus_ble_n}, {30'd0, e.bhe_n, e.ble_n});
                    check(bus_we == e.we, "R11", "direction", 32'(bus_we), 32'(e.we));
                    check(bus_wdata == e.wd, "R6", "lane write data", 32'(bus_wdata), 32'(e.wd));
                    if (bus_we) begin
                        if (!bus_ble_n) mem[32'({bus_waddr, 1'b0})] = bus_wdata[7:0];
                        if (!bus_bhe_n) mem[32'({bus_waddr, 1'b1})] = bus_wdata[15:8];
                    end
                    bus_rdata[7:0]  = !bus_ble_n ? mem_rd({bus_waddr, 1'b0}) : 8'hEE;
                    bus_rdata[15:8] = !bus_bhe_n ? mem_rd({bus_waddr, 1'b1}) : 8'hEE;
                    bus_ack = 1'b1;
                    cyc_seen++;
                    if (expq.size() == 0) done_due = 1;
                    wait_left = stall_pat % 3;
                    stall_pat++;
                end
            end
        end
    end

    task automatic xfer(input logic [23:0] a, input logic [1:0] sz, input bit wr,
                        input logic [31:0] wd, input bit poke);
        int n, k, rem, step, ncyc;
        logic [23:0] p;
        logic [31:0] exp_rd;
        exp_t e;
        n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        exp_rd = '0;
        for (int i = 0; i < n; i++) exp_rd[8*i +: 8] = mem_rd(a + 24'(i));
        p = a; k = 0; rem = n; ncyc = 0;
        while (rem > 0) begin
            e.wa = p[23:1];
            e.we = wr;
            if (p[0]) begin
                e.ble_n = 1; e.bhe_n = 0; step = 1;
                e.wd = wr ? {wd[8*k +: 8], 8'h00} : 16'h0;
            end else if (rem >= 2) begin
                e.ble_n = 0; e.bhe_n = 0; step = 2;
                e.wd = wr ? {wd[8*(k+1) +: 8], wd[8*k +: 8]} : 16'h0;
            end else begin
                e.ble_n = 0; e.bhe_n = 1; step = 1;
                e.wd = wr ? {8'h00, wd[8*k +: 8]} : 16'h0;
            end
            expq.push_back(e);
            p = p + 24'(step); k += step; rem -= step; ncyc++;
        end
        cyc_seen = 0;
        req_valid = 1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        check(busy == 1'b1, "R2", "busy after accept", 32'(busy), 32'd1);
        if (poke) begin
            req_valid = 1; req_addr = 24'h123456; req_size = 2'b10;
            req_write = ~wr; req_wdata = 32'hDEADBEEF;
            @(negedge clk);
            req_valid = 0;
        end
        while (!done) @(negedge clk);
        check(busy == 1'b0, "R2", "busy at done", 32'(busy), 32'd0);
        check(cyc_seen == ncyc, "R5", "bus cycle count", 32'(cyc_seen), 32'(ncyc));
        check(expq.size() == 0, "R5", "cycles left over", 32'(expq.size()), 32'd0);
        if (!wr) check(rdata == exp_rd, "R7", "read result", rdata, exp_rd);
    endtask

    initial begin : watchdog
        forever begin
            @(negedge clk);
            cycle_no++;
            if (cycle_no > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual=%0d expected<=%0d", cycle_no, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check(!bus_cyc && bus_ble_n && bus_bhe_n && !done && !busy, "R1", "state in reset",
              {27'd0, bus_cyc, bus_ble_n, bus_bhe_n, done, busy}, 32'b01100);
        rst = 0;
        @(negedge clk);
        check(!bus_cyc && bus_ble_n && bus_bhe_n && !done && !busy, "R1", "state after reset",
              {27'd0, bus_cyc, bus_ble_n, bus_bhe_n, done, busy}, 32'b01100);

        // aligned word, 2 cycles, R6/R7 round trip
        xfer(24'h000100, 2'b10, 1, 32'h44332211, 0);
        xfer(24'h000100, 2'b10, 0, 32'h0, 0);
        // single bytes on each lane, then a half read across them
        xfer(24'h000201, 2'b00, 1, 32'h000000AB, 0);
        xfer(24'h000200, 2'b00, 1, 32'h000000CD, 0);
        xfer(24'h000200, 2'b01, 0, 32'h0, 0);
        // odd half, split in two
        xfer(24'h0001FF, 2'b01, 1, 32'h00001234, 0);
        xfer(24'h0001FF, 2'b01, 0, 32'h0, 0);
        xfer(24'h0001FF, 2'b00, 0, 32'h0, 0);
        xfer(24'h000200, 2'b00, 0, 32'h0, 0);
        // odd word, 3 cycles
        xfer(24'h000103, 2'b10, 1, 32'h8899AABB, 0);
        xfer(24'h000103, 2'b10, 0, 32'h0, 0);
        xfer(24'h000104, 2'b01, 0, 32'h0, 0);
        // R9 wrap at the top of the address space
        xfer(24'hFFFFFF, 2'b10, 1, 32'hA1B2C3D4, 0);
        xfer(24'hFFFFFF, 2'b10, 0, 32'h0, 0);
        xfer(24'h000000, 2'b01, 0, 32'h0, 0);
        xfer(24'hFFFFFE, 2'b10, 0, 32'h0, 0);
        // R5 size code 11 behaves as four bytes
        xfer(24'h000305, 2'b11, 1, 32'h0F1E2D3C, 0);
        xfer(24'h000305, 2'b11, 0, 32'h0, 0);
        // R2 requests while busy are ignored
        xfer(24'h000401, 2'b10, 1, 32'h55667788, 1);
        xfer(24'h000401, 2'b10, 0, 32'h0, 1);
        xfer(24'h000402, 2'b00, 0, 32'h0, 1);
        // sweep of reads over starting offsets and sizes
        for (int a = 0; a < 8; a++) begin
            for (int s = 0; s < 3; s++) begin
                xfer(24'h000800 + 24'(a), 2'(s), 0, 32'h0, 0);
            end
        end
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule